// File: doc/BRIEF.md
# Multi-Source Node Reset Controller

This block turns the reset causes of one compute node into timed sequences on its reset outputs. There are two asynchronous inputs, power-good and an active-low external hard-reset line. There is a synchronous bus-error pulse. There are also three software-writable, self-clearing control bits: a system hard-reset request, a local node reset and a soft reset. Each cause runs its own assert/release sequence. Each sequence decides which of the core, processor and peripheral resets assert, and whether configuration registers keep their contents.

A system integrator usually loops the external reset-request output back onto the hard-reset input. That gives a warm reset that all nodes see at the same time. The cause register and the self-clearing bits are read-only outputs that a register bank can expose. The cause register is cleared only when power is lost.

Top module: `node_rst_ctrl`

## Requirements
- R1: While `pwr_ok` is low, the block is in its reset state: `core_rst`, `cpu_rst` and `periph_rst` are high, `init_pulse` and `ext_rst_req` are low, `cfg_keep` is low, `ctrl_bits` is 0 and `rst_cause` is 6'b000001 (power-up).
- R2: After `pwr_ok` rises, all three resets stay asserted for as long as `hard_rst_n_in` is low. Once it is released they stay asserted for exactly HOLD_CYCLES+2 more cycles (the 2 cycles are the two-flop synchroniser), then all reset outputs drop and `cfg_keep` goes high.
- R3: After power-up, a low level on `hard_rst_n_in` with `proc_only_sel` low asserts core, processor and peripheral resets with `cfg_keep` low. The release follows the R2 timing, and `rst_cause` becomes 6'b000010.
- R4: If `proc_only_sel` is high when a hard reset starts, only `core_rst` and `cpu_rst` assert, `periph_rst` stays low and `cfg_keep` stays high. `rst_cause` becomes 6'b000100.
- R5: A one-cycle `bus_err` pulse while idle asserts only `core_rst`, with `cfg_keep` high. The pulse is visible the cycle after the sampling edge, lasts exactly HOLD_CYCLES cycles, and `rst_cause` becomes 6'b001000.
- R6: Writing `sw_wdata` bit 1 (local node reset) asserts `core_rst`, `cpu_rst` and `periph_rst` for exactly HOLD_CYCLES cycles with `cfg_keep` high. The sequence starts the second cycle after the write, and `rst_cause` becomes 6'b010000.
- R7: Writing bit 2 (soft reset) asserts only `init_pulse`, for HOLD_CYCLES cycles. `rst_cause` becomes 6'b100000.
- R8: Writing bit 0 (system hard-reset request) asserts only `ext_rst_req`, for HOLD_CYCLES cycles, and leaves `rst_cause` unchanged.
- R9: A write while idle with no bit pending shows on `ctrl_bits` one cycle later. All pending bits clear in the cycle their sequence starts. A write made while a sequence runs is ignored.
- R10: When causes coincide, the order is hard input, then bus error, then system request, then local, then soft. Lower pending bits are dropped.
- R11: `rst_cause` is always one-hot. It changes only when a new sequence other than a system request starts, and it keeps its value through every warm reset.
- R12: A hard-reset input asserted during any warm sequence takes over at once with the hard-reset pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| pwr_ok | input | 1 | Asynchronous power-good, low clears the block |
| hard_rst_n_in | input | 1 | Asynchronous external hard reset, active low |
| proc_only_sel | input | 1 | Steers a hard reset to node and processors only |
| bus_err | input | 1 | Synchronous bus-error reset pulse |
| sw_wr | input | 1 | Control-bit write strobe |
| sw_wdata | input | 3 | Bit0 system request, bit1 local reset, bit2 soft reset |
| core_rst | output | 1 | Node core reset, active high |
| cpu_rst | output | 1 | Processor reset, active high |
| periph_rst | output | 1 | Peripheral interface reset, active high |
| ext_rst_req | output | 1 | External reset request, for loop-back to the hard input |
| init_pulse | output | 1 | Processor restart at boot vector |
| cfg_keep | output | 1 | High when configuration registers keep their values |
| ctrl_bits | output | 3 | Pending self-clearing control bits |
| rst_cause | output | 6 | One-hot last reset cause |

## Verification
The bench targets coincident causes. A design with the priority wrong would run the local or soft sequence in place of the bus-error reset, or keep a dropped bit pending so that an extra init pulse fires later. It writes control bits in the middle of a sequence. A design that accepted those writes would chain a second reset after the first. It asserts the hard input partway through a local reset and checks the release delay after the input returns high. A missing preemption, a lost synchroniser stage or an off-by-one hold counter would each show up as a wrong pattern or a wrong cycle count. It also alternates processor-only and full hard resets. A steering error there would pulse the peripheral reset or clear `cfg_keep` when configuration should be kept.

// File: rtl/nrc_pkg.sv
package nrc_pkg;

  typedef enum logic [2:0] {
    K_PWR   = 3'd0,
    K_HARD  = 3'd1,
    K_PROC  = 3'd2,
    K_BUS   = 3'd3,
    K_LOCAL = 3'd4,
    K_SOFT  = 3'd5,
    K_REQ   = 3'd6
  } rst_kind_e;

  typedef enum logic [1:0] {
    S_PWR  = 2'd0,
    S_HARD = 2'd1,
    S_HOLD = 2'd2,
    S_IDLE = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic core;
    logic cpu;
    logic periph;
    logic ext_req;
    logic init;
    logic cfg_keep;
  } rst_outs_t;

  localparam rst_outs_t IDLE_OUTS = rst_outs_t'(6'b000001);
  localparam int        CAUSE_W   = 6;
  localparam int        CTRL_W    = 3;

  // Output pattern for each kind of active sequence.
  function automatic rst_outs_t kind_outs(rst_kind_e k);
    rst_outs_t o;
    o = IDLE_OUTS;
    case (k)
      K_PWR, K_HARD: begin
        o.core = 1'b1; o.cpu = 1'b1; o.periph = 1'b1; o.cfg_keep = 1'b0;
      end
      K_PROC:  begin o.core = 1'b1; o.cpu = 1'b1; end
      K_BUS:   o.core = 1'b1;
      K_LOCAL: begin o.core = 1'b1; o.cpu = 1'b1; o.periph = 1'b1; end
      K_SOFT:  o.init = 1'b1;
      K_REQ:   o.ext_req = 1'b1;
      default: o = IDLE_OUTS;
    endcase
    return o;
  endfunction

  // One-hot cause code; zero for kinds that are not recorded.
  function automatic logic [CAUSE_W-1:0] cause_code(rst_kind_e k);
    logic [CAUSE_W-1:0] c;
    case (k)
      K_PWR:   c = 6'b000001;
      K_HARD:  c = 6'b000010;
      K_PROC:  c = 6'b000100;
      K_BUS:   c = 6'b001000;
      K_LOCAL: c = 6'b010000;
      K_SOFT:  c = 6'b100000;
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/nrc_sync.sv
module nrc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nrc_ctrl_reg.sv
module nrc_ctrl_reg
  import nrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              idle,
  input  logic              clear,
  output logic [CTRL_W-1:0] bits
);
  logic accept;

  // Writes land only in an idle controller with nothing pending.
  assign accept = wr && idle && (bits == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits <= '0;
    else if (clear)  bits <= '0;
    else if (accept) bits <= wdata;
  end
endmodule

// File: rtl/nrc_sequencer.sv
module nrc_sequencer
  import nrc_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hard_s,
  input  logic               proc_sel,
  input  logic               bus_err,
  input  logic               req_bit,
  input  logic               local_bit,
  input  logic               soft_bit,
  output seq_state_e         state,
  output rst_kind_e          kind,
  output logic               seq_start,
  output logic [CAUSE_W-1:0] cause
);
  localparam int              CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  seq_state_e       state_n;
  rst_kind_e        kind_n;
  logic [CNT_W-1:0] cnt;
  rst_kind_e        hard_kind;

  assign hard_kind = proc_sel ? K_PROC : K_HARD;

  always_comb begin
    state_n   = state;
    kind_n    = kind;
    seq_start = 1'b0;
    case (state)
      S_PWR:  if (!hard_s) state_n = S_HOLD;
      S_HARD: if (!hard_s) state_n = S_HOLD;
      S_HOLD: begin
        if (hard_s) begin
          state_n = S_HARD; kind_n = hard_kind; seq_start = 1'b1;
        end else if (cnt == LAST) begin
          state_n = S_IDLE;
        end
      end
      default: begin
        if (hard_s) begin
          state_n = S_HARD; kind_n = hard_kind; seq_start = 1'b1;
        end else if (bus_err) begin
          state_n = S_HOLD; kind_n = K_BUS; seq_start = 1'b1;
        end else if (req_bit) begin
          state_n = S_HOLD; kind_n = K_REQ; seq_start = 1'b1;
        end else if (local_bit) begin
          state_n = S_HOLD; kind_n = K_LOCAL; seq_start = 1'b1;
        end else if (soft_bit) begin
          state_n = S_HOLD; kind_n = K_SOFT; seq_start = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_PWR;
      kind  <= K_PWR;
      cnt   <= '0;
      cause <= cause_code(K_PWR);
    end else begin
      state <= state_n;
      kind  <= kind_n;
      if (state != S_HOLD) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
      if (seq_start && kind_n != K_REQ) cause <= cause_code(kind_n);
    end
  end
endmodule

// File: rtl/node_rst_ctrl.sv
module node_rst_ctrl
  import nrc_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                pwr_ok,
  input  logic                hard_rst_n_in,
  input  logic                proc_only_sel,
  input  logic                bus_err,
  input  logic                sw_wr,
  input  logic [CTRL_W-1:0]   sw_wdata,
  output logic                core_rst,
  output logic                cpu_rst,
  output logic                periph_rst,
  output logic                ext_rst_req,
  output logic                init_pulse,
  output logic                cfg_keep,
  output logic [CTRL_W-1:0]   ctrl_bits,
  output logic [CAUSE_W-1:0]  rst_cause
);
  // Named internal events, also used by the bound checker.
  logic       rst_n_int;
  logic       hard_s;
  logic       seq_start;
  logic       seq_busy;
  seq_state_e state;
  rst_kind_e  kind;
  rst_outs_t  outs;

  nrc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwr_sync (
    .clk(clk), .clr_n(pwr_ok), .d(1'b1), .q(rst_n_int)
  );

  nrc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hard_sync (
    .clk(clk), .clr_n(rst_n_int), .d(~hard_rst_n_in), .q(hard_s)
  );

  nrc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .wr(sw_wr), .wdata(sw_wdata),
    .idle(!seq_busy), .clear(seq_start), .bits(ctrl_bits)
  );

  nrc_sequencer #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n_int), .hard_s(hard_s), .proc_sel(proc_only_sel),
    .bus_err(bus_err), .req_bit(ctrl_bits[0]), .local_bit(ctrl_bits[1]),
    .soft_bit(ctrl_bits[2]), .state(state), .kind(kind),
    .seq_start(seq_start), .cause(rst_cause)
  );

  assign seq_busy = (state != S_IDLE);
  assign outs     = seq_busy ? kind_outs(kind) : IDLE_OUTS;

  assign core_rst    = outs.core;
  assign cpu_rst     = outs.cpu;
  assign periph_rst  = outs.periph;
  assign ext_rst_req = outs.ext_req;
  assign init_pulse  = outs.init;
  assign cfg_keep    = outs.cfg_keep;
endmodule

// File: rtl/nrc_checker.sv
module nrc_checker #(
  parameter int HOLD_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n_int,
  input logic       core_rst,
  input logic       cpu_rst,
  input logic       periph_rst,
  input logic       ext_rst_req,
  input logic       init_pulse,
  input logic       cfg_keep,
  input logic [2:0] ctrl_bits,
  input logic [5:0] rst_cause,
  input logic       sw_wr,
  input logic       seq_start,
  input logic       seq_busy
);
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   run <= '0;
    else if (core_rst) run <= (run == 16'hFFFF) ? run : run + 16'd1;
    else              run <= '0;
  end

  p_hold_min_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(core_rst) |-> run >= 16'(HOLD_CYCLES));

  p_init_alone_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    init_pulse |-> !(core_rst || cpu_rst || periph_rst || ext_rst_req));

  p_req_alone_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    ext_rst_req |-> !(core_rst || cpu_rst || periph_rst || init_pulse));

  p_cause_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n_int)
    $countones(rst_cause) == 1);

  p_cause_stable_r11: assert property (@(posedge clk) disable iff (!rst_n_int)
    !seq_start |=> $stable(rst_cause));

  p_ctrl_clear_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    seq_start |=> ctrl_bits == 3'b000);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (seq_busy && sw_wr) |=> ctrl_bits == 3'b000);

  p_cfg_wipe_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cfg_keep |-> (core_rst && cpu_rst && periph_rst));

  p_proc_keep_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cpu_rst && !periph_rst) |-> cfg_keep);
endmodule

bind node_rst_ctrl nrc_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk), .rst_n_int(rst_n_int), .core_rst(core_rst), .cpu_rst(cpu_rst),
  .periph_rst(periph_rst), .ext_rst_req(ext_rst_req), .init_pulse(init_pulse),
  .cfg_keep(cfg_keep), .ctrl_bits(ctrl_bits), .rst_cause(rst_cause),
  .sw_wr(sw_wr), .seq_start(seq_start), .seq_busy(seq_busy)
);

// File: tb/node_rst_ctrl_tb_top.sv
`timescale 1ns/1ps
module node_rst_ctrl_tb_top;
  localparam int HOLD = 16;
  localparam int KH = 0, KP = 1, KB = 2, KL = 3, KS = 4, KR = 5;

  logic       clk = 1'b0;
  logic       pwr_ok = 1'b0;
  logic       hard_rst_n_in = 1'b0;
  logic       proc_only_sel = 1'b0;
  logic       bus_err = 1'b0;
  logic       sw_wr = 1'b0;
  logic [2:0] sw_wdata = 3'b000;
  logic       core_rst, cpu_rst, periph_rst, ext_rst_req, init_pulse, cfg_keep;
  logic [2:0] ctrl_bits;
  logic [5:0] rst_cause;

  int n_chk = 0;
  int n_fail = 0;
  logic [5:0] cur_cause = 6'b000001;

  always #2 clk = ~clk;

  node_rst_ctrl #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .pwr_ok(pwr_ok), .hard_rst_n_in(hard_rst_n_in),
    .proc_only_sel(proc_only_sel), .bus_err(bus_err), .sw_wr(sw_wr),
    .sw_wdata(sw_wdata), .core_rst(core_rst), .cpu_rst(cpu_rst),
    .periph_rst(periph_rst), .ext_rst_req(ext_rst_req), .init_pulse(init_pulse),
    .cfg_keep(cfg_keep), .ctrl_bits(ctrl_bits), .rst_cause(rst_cause)
  );

  // {core, cpu, periph, ext_req, init, cfg_keep}
  localparam logic [5:0] IDLE = 6'b000001;

  function automatic logic [5:0] outs();
    return {core_rst, cpu_rst, periph_rst, ext_rst_req, init_pulse, cfg_keep};
  endfunction

  function automatic logic [5:0] exp_pat(int k);
    case (k)
      KH:      return 6'b111000;
      KP:      return 6'b110001;
      KB:      return 6'b100001;
      KL:      return 6'b111001;
      KS:      return 6'b000011;
      default: return 6'b000101;
    endcase
  endfunction

  function automatic logic [5:0] exp_cause(int k, logic [5:0] prev);
    case (k)
      KH:      return 6'b000010;
      KP:      return 6'b000100;
      KB:      return 6'b001000;
      KL:      return 6'b010000;
      KS:      return 6'b100000;
      default: return prev;
    endcase
  endfunction

  function automatic logic [2:0] bit_of(int k);
    case (k)
      KR:      return 3'b001;
      KL:      return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Warm causes: bus pulse and/or a control write; expect kind k to win.
  task automatic warm(string req, bit bus, logic [2:0] wd, int k);
    int d, len;
    logic [5:0] pat;
    bus_err = bus; sw_wr = (wd != 3'b000); sw_wdata = wd;
    @(negedge clk);
    bus_err = 1'b0; sw_wr = 1'b0;
    if (!bus && wd != 3'b000) chk({req, " R9 write visible"}, ctrl_bits, wd);
    d = 0;
    while (outs() == IDLE && d < 8) begin @(negedge clk); d++; end
    chk({req, " R9 start delay"}, d, bus ? 0 : 1);
    chk({req, " R9 bits cleared"}, ctrl_bits, 3'b000);
    pat = outs();
    chk({req, " pattern"}, pat, exp_pat(k));
    len = 0;
    while (outs() == pat && len < 100) begin len++; @(negedge clk); end
    chk({req, " hold length"}, len, HOLD);
    cur_cause = exp_cause(k, cur_cause);
    chk({req, " R11 cause"}, rst_cause, cur_cause);
    repeat (4) @(negedge clk);
    chk({req, " R10 idle after, nothing pending"}, {outs(), ctrl_bits}, {IDLE, 3'b000});
  endtask

  task automatic hard(string req, bit proc, int low);
    int len;
    logic [5:0] pat;
    proc_only_sel = proc; hard_rst_n_in = 1'b0;
    repeat (low) @(negedge clk);
    pat = proc ? exp_pat(KP) : exp_pat(KH);
    chk({req, " pattern while held"}, outs(), pat);
    hard_rst_n_in = 1'b1;
    @(negedge clk);
    len = 0;
    while (outs() == pat && len < 100) begin len++; @(negedge clk); end
    chk({req, " release length"}, len, HOLD + 2);
    chk({req, " idle after"}, outs(), IDLE);
    cur_cause = exp_cause(proc ? KP : KH, cur_cause);
    chk({req, " R11 cause"}, rst_cause, cur_cause);
    proc_only_sel = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int len;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: held in reset while power is not good
    chk("R1 outputs", outs(), 6'b111000);
    chk("R1 ctrl", ctrl_bits, 3'b000);
    chk("R1 cause", rst_cause, 6'b000001);
    // R2: power good first, hard input released later
    pwr_ok = 1'b1;
    repeat (8) @(negedge clk);
    chk("R2 held until hard release", outs(), 6'b111000);
    hard_rst_n_in = 1'b1;
    @(negedge clk);
    len = 0;
    while (outs() == 6'b111000 && len < 100) begin len++; @(negedge clk); end
    chk("R2 release length", len, HOLD + 2);
    chk("R2 idle", outs(), IDLE);
    chk("R2 cause power-up", rst_cause, 6'b000001);
    repeat (2) @(negedge clk);

    hard("R3 hard", 1'b0, 6);
    hard("R4 proc-only", 1'b1, 5);
    warm("R5 bus error", 1'b1, 3'b000, KB);
    warm("R6 local", 1'b0, 3'b010, KL);
    warm("R7 soft", 1'b0, 3'b100, KS);
    warm("R8 request", 1'b0, 3'b001, KR);
    // R10 priorities
    warm("R10 bus over local", 1'b1, 3'b010, KB);
    warm("R10 local over soft", 1'b0, 3'b110, KL);
    warm("R10 request over local", 1'b0, 3'b011, KR);

    // R9: write during a running sequence is ignored
    sw_wr = 1'b1; sw_wdata = 3'b010;
    @(negedge clk); sw_wr = 1'b0;
    repeat (5) @(negedge clk);
    sw_wr = 1'b1; sw_wdata = 3'b100;
    @(negedge clk); sw_wr = 1'b0;
    chk("R9 busy write ignored", ctrl_bits, 3'b000);
    repeat (HOLD + 2) @(negedge clk);
    chk("R9 no chained soft reset", {outs(), ctrl_bits}, {IDLE, 3'b000});
    cur_cause = 6'b010000;
    chk("R11 cause after local", rst_cause, cur_cause);

    // R12: hard input preempts a local reset
    sw_wr = 1'b1; sw_wdata = 3'b010;
    @(negedge clk); sw_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R12 local running", outs(), exp_pat(KL));
    hard("R12 preempt", 1'b0, 6);

    // Constrained random sequence of causes
    for (int i = 0; i < 40; i++) begin
      int k;
      k = int'($urandom_range(0, 5));
      case (k)
        KH:      hard("R3 rand hard", 1'b0, int'($urandom_range(4, 12)));
        KP:      hard("R4 rand proc", 1'b1, int'($urandom_range(4, 12)));
        KB:      warm("R5 rand bus", 1'b1, 3'b000, KB);
        default: warm("R6 rand sw", 1'b0, bit_of(k), k);
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule